// File: doc/BRIEF.md
# Transfer Task Progress Tracker

This block keeps count for four independent transfer tasks that a serial-bus master engine works through. Software programs each task with a start address and a byte count, then arms it. The bus engine pulses a per-task strobe for every byte moved. The tracker steps a current-address output that an external data mover uses, and counts the remaining bytes down. It raises an event when half of the programmed count has been moved and another when all of it has. With the reload option set, the task wraps back to its programmed address and count after completion, which gives circular double-buffer operation.

NACK and bus-error strobes from the bus engine stop the affected task. All sixteen events (four kinds for each of four tasks) are collected into one pending register that is cleared by writing ones. An enable register masks the pending bits onto a single interrupt line. A shared config register holds one bit per task that tells the bus engine not to issue a stop condition after that task.

Register map (byte offsets):
- 0x010: interrupt enable.
- 0x014: pending, cleared by writing ones.
- 0x020: stop suppression, bit n for task n.
- Task n has its group at 0x100 + 0x40·n:
  - +0x0: control, where bit 31 is the software start.
  - +0x4: transfer control, where bit 0 arms the task and bit 1 selects reload.
  - +0x8: start address.
  - +0xC: byte count.
  - +0x10: remaining count, read-only.

Top module: `xfer_task_tracker`

## Requirements
- R1: After reset, every register reads as zero. `irq_o`, `nostop_o` and every current address are 0.
- R2: Writing the transfer-control word (+0x4) with bit 0 set loads the remaining count (+0x10) from the byte count (+0xC). It also loads the task's current address from the start address (+0x8).
- R3: A task is active while transfer-control bit 0 and control bit 31 are both 1. A byte strobe for an active task with a nonzero remaining count decrements that count and increments its current address by one. Other tasks are not affected.
- R4: Half-complete sets pending bit 4+n. It fires on the strobe after which the number of bytes moved equals floor(count/2), provided that value is nonzero.
- R5: Complete sets pending bit n on the strobe that brings the remaining count to 0. Without reload, this clears transfer-control bit 0, and later strobes change nothing.
- R6: With reload (transfer-control bit 1) set, completion restores the remaining count and the current address to their programmed values. The task stays active.
- R7: Writing 0 to transfer control, or clearing control bit 31, stops the task. Later strobes leave its remaining count and address unchanged.
- R8: A NACK strobe sets pending bit 8+n and a bus-error strobe sets pending bit 12+n. Either one clears transfer-control bit 0, whether or not reload is set.
- R9: Writing 1 to a pending bit (0x014) clears it. Bits written 0 are unchanged, so writing back the value just read clears all of them.
- R10: If an event sets a pending bit in the same cycle that a write tries to clear it, the bit stays set.
- R11: `irq_o` is registered. It is 1 in the cycle after any bit of (pending AND enable at 0x010) is 1, and 0 otherwise.
- R12: `nostop_o[n]` follows bit n of the stop-suppression register (0x020) from the cycle after the write.
- R13: `reg_rdata` gives, one clock after `reg_addr` is presented, the register at that address. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| byte_done_i | input | 4 | One byte moved, per task |
| nack_i | input | 4 | NACK seen, per task |
| err_i | input | 4 | Bus error seen, per task |
| nostop_o | output | 4 | Suppress stop after task, per task |
| cur_addr_o | output | 128 | Current address of each task, task n in bits 32n+31:32n |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can fall in the same cycle are a hardware event setting a pending bit and a software write-1 clear of that same bit. The bench provokes this by arming a one-byte task, then pulsing its byte strobe in the same cycle as a write to the pending register that holds the task's complete bit. A later read must still show that bit set, while a plain clear without a competing event is shown to work. A second overlap, a register write into a task group during a byte strobe, is covered by the load behaviour of R2 and by assertions on the counter.

// File: rtl/xtt_pkg.sv
package xtt_pkg;
  // event kinds; index selects the 4-bit group in the pending word
  localparam int EVT_DONE = 0;
  localparam int EVT_HALF = 1;
  localparam int EVT_NACK = 2;
  localparam int EVT_ERR  = 3;
  localparam int NUM_EVT  = 4;

  // shared register byte offsets
  localparam int OFS_IRQ_EN = 'h10;
  localparam int OFS_PEND   = 'h14;
  localparam int OFS_NOSTOP = 'h20;

  // word index inside one task group
  typedef enum logic [3:0] {
    TW_CTL   = 4'd0,
    TW_XCTL  = 4'd1,
    TW_BASE  = 4'd2,
    TW_COUNT = 4'd3,
    TW_REM   = 4'd4
  } task_word_e;
endpackage

// File: rtl/xtt_task_chan.sv
module xtt_task_chan import xtt_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [3:0]        woff_i,
  input  logic [31:0]       wdata_i,
  input  logic              byte_i,
  input  logic              nack_i,
  input  logic              err_i,
  output logic [31:0]       ctl_q,
  output logic [1:0]        xctl_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  rem_q,
  output logic [ADDR_W-1:0] cur_q,
  output logic [NUM_EVT-1:0] evt_o
);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic             active;
  logic             fire;
  logic [CNT_W-1:0] rem_nx;
  logic [CNT_W-1:0] moved_nx;
  logic [CNT_W-1:0] half_mark;
  logic             hit_half;
  logic             hit_done;
  logic             abort;

  assign active    = xctl_q[0] & ctl_q[31];
  assign fire      = active & byte_i & (rem_q != '0) & ~wr_i;
  assign rem_nx    = rem_q - CNT_ONE;
  assign moved_nx  = count_q - rem_nx;
  assign half_mark = count_q >> 1;
  assign hit_half  = fire & (half_mark != '0) & (moved_nx == half_mark);
  assign hit_done  = fire & (rem_nx == '0);
  assign abort     = nack_i | err_i;

  always_comb begin
    evt_o           = '0;
    evt_o[EVT_DONE] = hit_done;
    evt_o[EVT_HALF] = hit_half;
    evt_o[EVT_NACK] = nack_i;
    evt_o[EVT_ERR]  = err_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= '0;
      xctl_q  <= '0;
      base_q  <= '0;
      count_q <= '0;
      rem_q   <= '0;
      cur_q   <= '0;
    end else begin
      if (wr_i) begin
        case (woff_i)
          TW_CTL:   ctl_q <= wdata_i;
          TW_XCTL: begin
            xctl_q <= wdata_i[1:0];
            if (wdata_i[0]) begin
              rem_q <= count_q;
              cur_q <= base_q;
            end
          end
          TW_BASE:  base_q  <= wdata_i[ADDR_W-1:0];
          TW_COUNT: count_q <= wdata_i[CNT_W-1:0];
          default: ;
        endcase
      end else if (fire) begin
        if (hit_done && xctl_q[1]) begin
          rem_q <= count_q;
          cur_q <= base_q;
        end else begin
          rem_q <= rem_nx;
          cur_q <= cur_q + ADDR_ONE;
          if (hit_done) xctl_q[0] <= 1'b0;
        end
      end
      if (abort) xctl_q[0] <= 1'b0;
    end
  end

  // R3: a counted byte steps the remaining count down by one
  p_rem_step_r3: assert property (@(posedge clk) disable iff (rst)
    (active && byte_i && !wr_i && rem_q > CNT_ONE) |=> (rem_q == $past(rem_q) - CNT_ONE));

  // R7: an idle task keeps its count
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!active && !wr_i) |=> $stable(rem_q));

  // R8: NACK or bus error disarms the task
  p_abort_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (abort && !wr_i) |=> !xctl_q[0]);

  // R5: last byte without reload disarms the task
  p_done_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (active && byte_i && !wr_i && rem_q == CNT_ONE && !xctl_q[1]) |=> (!xctl_q[0] && rem_q == '0));
endmodule

// File: rtl/xtt_irq_matrix.sv
module xtt_irq_matrix #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] set_i,
  input  logic          wr_en_i,
  input  logic          wr_clr_i,
  input  logic [PW-1:0] wdata_i,
  output logic [PW-1:0] en_q,
  output logic [PW-1:0] pend_q,
  output logic          irq_o
);
  logic [PW-1:0] clr_mask;

  assign clr_mask = wr_clr_i ? wdata_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (wr_en_i) en_q <= wdata_i;
      pend_q <= (pend_q & ~clr_mask) | set_i;
      irq_o  <= |(pend_q & en_q);
    end
  end

  // R10: a raised event is never lost to a same-cycle clear
  p_set_kept_r10: assert property (@(posedge clk) disable iff (rst)
    (set_i != '0) |=> ((pend_q & $past(set_i)) == $past(set_i)));

  // R9: bits written with one and not raised again are gone
  p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
    wr_clr_i |=> ((pend_q & $past(wdata_i & ~set_i)) == '0));
endmodule

// File: rtl/xfer_task_tracker.sv
module xfer_task_tracker import xtt_pkg::*; #(
  parameter int NTASK  = 4,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int RA_W   = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [RA_W-1:0]         reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NTASK-1:0]        byte_done_i,
  input  logic [NTASK-1:0]        nack_i,
  input  logic [NTASK-1:0]        err_i,
  output logic [NTASK-1:0]        nostop_o,
  output logic [NTASK*ADDR_W-1:0] cur_addr_o,
  output logic                    irq_o
);
  localparam int PW    = NUM_EVT * NTASK;
  localparam int TSL_W = 2;

  logic              word_ok;
  logic              in_task;
  logic [TSL_W-1:0]  tsel;
  logic [3:0]        woff;
  logic              wr_en_reg;
  logic              wr_pend;
  logic              wr_nostop;

  logic [31:0]       ctl_a   [NTASK];
  logic [1:0]        xctl_a  [NTASK];
  logic [ADDR_W-1:0] base_a  [NTASK];
  logic [CNT_W-1:0]  count_a [NTASK];
  logic [CNT_W-1:0]  rem_a   [NTASK];
  logic [NUM_EVT-1:0] evt_a  [NTASK];

  logic [PW-1:0]     set_w;
  logic [PW-1:0]     en_w;
  logic [PW-1:0]     pend_w;
  logic [31:0]       rd_nx;

  assign word_ok   = (reg_addr[1:0] == 2'b00);
  assign in_task   = word_ok && (reg_addr[RA_W-1:8] == (RA_W-8)'(1));
  assign tsel      = reg_addr[7:6];
  assign woff      = reg_addr[5:2];
  assign wr_en_reg = reg_we && (reg_addr == RA_W'(OFS_IRQ_EN));
  assign wr_pend   = reg_we && (reg_addr == RA_W'(OFS_PEND));
  assign wr_nostop = reg_we && (reg_addr == RA_W'(OFS_NOSTOP));

  for (genvar g = 0; g < NTASK; g++) begin : g_task
    logic [ADDR_W-1:0] cur_w;

    xtt_task_chan #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W)
    ) chan_i (
      .clk     (clk),
      .rst     (rst),
      .wr_i    (reg_we && in_task && (tsel == TSL_W'(g))),
      .woff_i  (woff),
      .wdata_i (reg_wdata),
      .byte_i  (byte_done_i[g]),
      .nack_i  (nack_i[g]),
      .err_i   (err_i[g]),
      .ctl_q   (ctl_a[g]),
      .xctl_q  (xctl_a[g]),
      .base_q  (base_a[g]),
      .count_q (count_a[g]),
      .rem_q   (rem_a[g]),
      .cur_q   (cur_w),
      .evt_o   (evt_a[g])
    );

    assign cur_addr_o[g*ADDR_W +: ADDR_W] = cur_w;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
      assign set_w[e*NTASK + g] = evt_a[g][e];
    end
  end

  xtt_irq_matrix #(
    .PW (PW)
  ) irq_i (
    .clk      (clk),
    .rst      (rst),
    .set_i    (set_w),
    .wr_en_i  (wr_en_reg),
    .wr_clr_i (wr_pend),
    .wdata_i  (reg_wdata[PW-1:0]),
    .en_q     (en_w),
    .pend_q   (pend_w),
    .irq_o    (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) nostop_o <= '0;
    else if (wr_nostop) nostop_o <= reg_wdata[NTASK-1:0];
  end

  always_comb begin
    rd_nx = '0;
    if (reg_addr == RA_W'(OFS_IRQ_EN))      rd_nx = 32'(en_w);
    else if (reg_addr == RA_W'(OFS_PEND))   rd_nx = 32'(pend_w);
    else if (reg_addr == RA_W'(OFS_NOSTOP)) rd_nx = 32'(nostop_o);
    else if (in_task && (32'(tsel) < NTASK)) begin
      case (woff)
        TW_CTL:   rd_nx = ctl_a[tsel];
        TW_XCTL:  rd_nx = 32'(xctl_a[tsel]);
        TW_BASE:  rd_nx = 32'(base_a[tsel]);
        TW_COUNT: rd_nx = 32'(count_a[tsel]);
        TW_REM:   rd_nx = 32'(rem_a[tsel]);
        default:  rd_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nx;
  end

  // R12: stop suppression takes the written bits
  p_nostop_load_r12: assert property (@(posedge clk) disable iff (rst)
    wr_nostop |=> (nostop_o == $past(reg_wdata[NTASK-1:0])));
endmodule

// File: tb/xfer_task_tracker_tb_top.sv
module xfer_task_tracker_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         reg_we = 1'b0;
  logic [9:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [3:0]   byte_done = '0;
  logic [3:0]   nack = '0;
  logic [3:0]   err = '0;
  logic [3:0]   nostop;
  logic [127:0] cur_addr;
  logic         irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xfer_task_tracker dut_i (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .byte_done_i (byte_done),
    .nack_i      (nack),
    .err_i       (err),
    .nostop_o    (nostop),
    .cur_addr_o  (cur_addr),
    .irq_o       (irq)
  );

  // {count, byte strobes, expected remaining, expected pending}
  localparam logic [63:0] VEC [7] = '{
    {16'd8, 16'd3,  16'd5, 16'h0000},
    {16'd8, 16'd4,  16'd4, 16'h0010},
    {16'd8, 16'd8,  16'd0, 16'h0011},
    {16'd5, 16'd2,  16'd3, 16'h0010},
    {16'd1, 16'd1,  16'd0, 16'h0001},
    {16'd8, 16'd10, 16'd0, 16'h0011},
    {16'd7, 16'd3,  16'd4, 16'h0010}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic pulse_byte(input int t);
    @(negedge clk);
    byte_done[t] = 1'b1;
    @(negedge clk);
    byte_done = '0;
  endtask

  task automatic arm(input int t, input logic [31:0] cnt, input logic [31:0] base, input logic [1:0] mode);
    wr(10'(32'h100 + 32'h40*t + 32'h4), 32'h0);
    wr(10'(32'h100 + 32'h40*t + 32'hC), cnt);
    wr(10'(32'h100 + 32'h40*t + 32'h8), base);
    wr(10'(32'h100 + 32'h40*t), 32'h8000_0000);
    wr(10'(32'h100 + 32'h40*t + 32'h4), {30'd0, mode});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(10'h110, v); check("R1 remaining", v, 0);
    rd(10'h014, v); check("R1 pending", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 nostop", {28'd0, nostop}, 0);
    check("R1 addr", cur_addr[31:0], 0);

    // table walk on task 0: R2 R3 R4 R5
    for (int i = 0; i < 7; i++) begin
      logic [15:0] c, n, er, ep;
      {c, n, er, ep} = VEC[i];
      arm(0, 32'(c), 32'h2000, 2'b01);
      for (int k = 0; k < int'(n); k++) pulse_byte(0);
      rd(10'h110, v); check("R2/R5 remaining", v, 32'(er));
      rd(10'h014, v); check("R4/R5 pending", v, 32'(ep));
      check("R3 address", cur_addr[31:0], 32'h2000 + 32'((n < c) ? n : c));
      wr(10'h014, 32'hFFFF);
    end

    // R6 reload
    arm(0, 4, 32'h3000, 2'b11);
    for (int k = 0; k < 4; k++) pulse_byte(0);
    rd(10'h110, v); check("R6 remaining restored", v, 4);
    check("R6 address restored", cur_addr[31:0], 32'h3000);
    rd(10'h014, v); check("R6 pending", v, 32'h11);
    wr(10'h014, 32'hFFFF);
    pulse_byte(0); pulse_byte(0);
    rd(10'h110, v); check("R6 still running", v, 2);
    rd(10'h014, v); check("R6 half again", v, 32'h10);
    wr(10'h014, v);
    rd(10'h014, v); check("R9 write-back clears", v, 0);

    // R7 stop via control bit 31 and via transfer control
    arm(1, 6, 32'h500, 2'b01);
    pulse_byte(1);
    rd(10'h150, v); check("R3 task1 step", v, 5);
    wr(10'h140, 32'h0);
    pulse_byte(1);
    rd(10'h150, v); check("R7 ctl cleared holds", v, 5);
    wr(10'h140, 32'h8000_0000);
    pulse_byte(1);
    rd(10'h150, v); check("R7 resumed", v, 4);
    wr(10'h144, 32'h0);
    pulse_byte(1);
    rd(10'h150, v); check("R7 xctl zero holds", v, 4);
    check("R7 address held", cur_addr[63:32], 32'h502);
    rd(10'h110, v); check("R3 task0 untouched", v, 2);

    // R8 NACK on task 2, bus error on task 3
    arm(2, 10, 32'h0, 2'b11);
    pulse_byte(2);
    @(negedge clk); nack[2] = 1'b1;
    @(negedge clk); nack = '0;
    pulse_byte(2);
    rd(10'h190, v); check("R8 nack stops task", v, 9);
    rd(10'h184, v); check("R8 start bit cleared", v, 32'h2);
    arm(3, 10, 32'h0, 2'b01);
    @(negedge clk); err[3] = 1'b1;
    @(negedge clk); err = '0;
    rd(10'h014, v); check("R8 pending bits", v, 32'h8400);

    // R11 interrupt masking
    wr(10'h010, 32'h0001);
    @(negedge clk);
    check("R11 masked", {31'd0, irq}, 0);
    wr(10'h010, 32'h0400);
    @(negedge clk);
    check("R11 enabled", {31'd0, irq}, 1);
    wr(10'h014, 32'h0400);
    @(negedge clk);
    check("R11 drops", {31'd0, irq}, 0);
    rd(10'h014, v); check("R9 partial clear", v, 32'h8000);
    rd(10'h010, v); check("R13 enable readback", v, 32'h0400);
    wr(10'h014, 32'hFFFF);

    // R10 set beats clear in same cycle (task 1, one byte)
    wr(10'h14C, 1);
    wr(10'h144, 1);
    @(negedge clk);
    byte_done[1] = 1'b1;
    reg_we = 1'b1; reg_addr = 10'h014; reg_wdata = 32'h0002;
    @(negedge clk);
    byte_done = '0; reg_we = 1'b0;
    rd(10'h014, v); check("R10 set wins", v & 32'h2, 32'h2);

    // R12 stop suppression
    wr(10'h020, 32'h5);
    check("R12 nostop", {28'd0, nostop}, 32'h5);
    rd(10'h020, v); check("R13 nostop readback", v, 32'h5);
    rd(10'h3FC, v); check("R13 unmapped", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule